// File: doc/BRIEF.md
# Mode-Aware Bidirectional I/O Port

This block is an eight-pin general-purpose port that sits on a microcontroller's internal byte bus. It holds two registers at fixed bus addresses. The direction register can only be written. The data register can be written and read. Each pin gets an output-enable and an output value from the block, and the block receives the pin's input level.

The chip operating mode decides what a set direction bit means. In single-chip operation, a set bit turns its pin into a general-purpose output. In the expanded modes that keep on-chip memory, a set bit turns the pin into an address output. In the expanded modes that run without on-chip memory, every pin is forced to address output.

Reset and hardware standby both clear the direction register. Software standby leaves it alone, so output pins keep driving through that standby.

Top module: `mode_io_port`

## Requirements
- R1: After reset the direction register and the data register hold 0x00. In single-chip mode every output enable is low and every output value is 0.
- R2: In single-chip mode (any mode code other than 1, 2, 3 or 4), pin i has its output enable equal to direction bit i, and its output value equal to data bit i.
- R3: A read at 0xFF88 (direction register) returns 0xFF whatever is stored. A write at 0xFF88 updates the direction bits.
- R4: A read at 0xFF8A (data register) returns, per pin, the stored data bit if the pin's effective direction is 1, and the synchronized pin level if it is 0. A write at 0xFF8A updates the data bits.
- R5: A pin level that changes just before clock edge k becomes visible in a data register read after edge k+1, and not after edge k alone.
- R6: While hardware standby is high, every output enable is low at once, without waiting for a clock edge. The direction register is cleared to 0x00 and holds that value until standby ends. The data register keeps its value.
- R7: Software standby changes nothing: direction bits, data bits and pin outputs stay as they were.
- R8: In modes 2 and 4, pin i with direction bit 1 is enabled and drives address bit i. Pin i with direction bit 0 is disabled and readable as an input.
- R9: In modes 1 and 3, every output enable is high, every pin drives its address bit, and writes to the direction register have no effect.
- R10: The mode input is captured while reset is asserted. Changes to it after reset have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset; mode is captured while it is low |
| modeSel | input | 3 | Chip operating mode code |
| hwStandby | input | 1 | Hardware standby, active high |
| swStandby | input | 1 | Software standby, active high |
| busAddr | input | 16 | Bus address |
| busWrEn | input | 1 | Write strobe, acted on at the clock edge |
| busRdEn | input | 1 | Read strobe; read data is combinational |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, 0 when no register is selected |
| extAddr | input | 8 | Address bits from the bus controller |
| padIn | input | 8 | Pin input levels |
| padOe | output | 8 | Pin output enables |
| padOut | output | 8 | Pin output values |

## Verification
The bench builds the block with its default values: eight pins, a 16-bit address, and the two register addresses 0xFF88 and 0xFF8A. With eight pins, random direction and data bytes give mixed input/output patterns per pin. Every pin's readback path is reached in each of the three mode classes. The fixed register addresses let directed cases write to neighbouring addresses, and let them write to the direction register while it is locked in the modes without on-chip memory.

// File: rtl/mode_io_pkg.sv
package mode_io_pkg;

  typedef enum logic [1:0] {
    MC_SINGLE    = 2'd0,
    MC_EXP_ROM   = 2'd1,
    MC_EXP_NOROM = 2'd2
  } modeClass_e;

  typedef struct packed {
    logic wrDir;
    logic wrData;
    logic rdDir;
    logic rdData;
  } ioStrobe_t;

  function automatic modeClass_e classifyMode(input logic [2:0] code);
    case (code)
      3'd1, 3'd3: classifyMode = MC_EXP_NOROM;
      3'd2, 3'd4: classifyMode = MC_EXP_ROM;
      default:    classifyMode = MC_SINGLE;
    endcase
  endfunction

endpackage

// File: rtl/mode_io_ctrl.sv
module mode_io_ctrl
  import mode_io_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFF88,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFF8A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output modeClass_e        modeClass,
  output ioStrobe_t         strobe
);

  logic [2:0] modeReg;

  // Mode is loaded on every edge while reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= modeSel;
  end

  assign modeClass = classifyMode(modeReg);

  logic hitDir, hitData;
  assign hitDir  = (busAddr == DIR_ADDR);
  assign hitData = (busAddr == DATA_ADDR);

  always_comb begin
    strobe.wrDir  = busWrEn && hitDir && (modeClass != MC_EXP_NOROM);
    strobe.wrData = busWrEn && hitData;
    strobe.rdDir  = busRdEn && hitDir;
    strobe.rdData = busRdEn && hitData;
  end

endmodule

// File: rtl/mode_io_dp.sv
module mode_io_dp
  import mode_io_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hwStandby,
  input  modeClass_e       modeClass,
  input  ioStrobe_t        strobe,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic [WIDTH-1:0] extAddr,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut
);

  logic [WIDTH-1:0] dirReg, dataReg, syncA, syncB, effDir;
  logic             dirClrN;

  assign dirClrN = rstN & ~hwStandby;

  always_ff @(posedge clk or negedge dirClrN) begin
    if (!dirClrN)          dirReg <= '0;
    else if (strobe.wrDir) dirReg <= busWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      if (strobe.wrData) dataReg <= busWrData;
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign effDir = (modeClass == MC_EXP_NOROM) ? '1 : dirReg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      padOe[i] = effDir[i] & ~hwStandby;
      unique case (modeClass)
        MC_EXP_NOROM: padOut[i] = extAddr[i];
        MC_EXP_ROM:   padOut[i] = dirReg[i] ? extAddr[i] : dataReg[i];
        default:      padOut[i] = dataReg[i];
      endcase
    end
  end

  always_comb begin
    if (strobe.rdDir)       busRdData = '1;
    else if (strobe.rdData) busRdData = (effDir & dataReg) | (~effDir & syncB);
    else                    busRdData = '0;
  end

endmodule

// File: rtl/mode_io_port.sv
module mode_io_port
  import mode_io_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 16'hFF88,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFF8A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        modeSel,
  input  logic              hwStandby,
  input  logic              swStandby,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [WIDTH-1:0]  busWrData,
  output logic [WIDTH-1:0]  busRdData,
  input  logic [WIDTH-1:0]  extAddr,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut
);

  modeClass_e modeClass;
  ioStrobe_t  strobe;
  logic       unusedSw;

  // Software standby needs no action: registers simply hold.
  assign unusedSw = swStandby;

  mode_io_ctrl #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .modeClass(modeClass), .strobe(strobe)
  );

  mode_io_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .modeClass(modeClass),
    .strobe(strobe), .busWrData(busWrData), .busRdData(busRdData),
    .extAddr(extAddr), .padIn(padIn), .padOe(padOe), .padOut(padOut)
  );

endmodule

// File: rtl/mode_io_port_chk.sv
module mode_io_port_chk
  import mode_io_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 16'hFF88
) (
  input logic              clk,
  input logic              rstN,
  input logic              hwStandby,
  input logic              swStandby,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [WIDTH-1:0]  busRdData,
  input logic [WIDTH-1:0]  extAddr,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padOut,
  input modeClass_e        modeClass
);

  p_hw_oe_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    hwStandby |-> (padOe == '0));

  p_dir_reads_ones_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == DIR_ADDR) |-> (busRdData == '1));

  p_romless_all_out_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeClass == MC_EXP_NOROM && !hwStandby) |-> (padOe == '1 && padOut == extAddr));

  p_sw_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (swStandby && !busWrEn && !hwStandby) |=> (hwStandby || $stable(padOe)));

  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeClass));

endmodule

bind mode_io_port mode_io_port_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .hwStandby(hwStandby), .swStandby(swStandby),
  .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busRdData(busRdData), .extAddr(extAddr), .padOe(padOe), .padOut(padOut),
  .modeClass(modeClass)
);

// File: tb/tb_mode_io_port.sv
`timescale 1ns/1ps
module tb_mode_io_port;

  localparam logic [15:0] DIRA = 16'hFF88;
  localparam logic [15:0] DATA = 16'hFF8A;

  logic        clk = 0, rstN = 0, hwStandby = 0, swStandby = 0;
  logic        busWrEn = 0, busRdEn = 0;
  logic [2:0]  modeSel = 3'd7;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0, extAddr = '0, padIn = '0;
  logic [7:0]  busRdData, padOe, padOut;

  int nChecks = 0, nFail = 0;
  logic [7:0] mDir, mData, mPin, rv;

  always #2.5 clk = ~clk;

  mode_io_port dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [2:0] m);
    @(negedge clk);
    rstN = 0; modeSel = m; hwStandby = 0; swStandby = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1;
    #1 d = busRdData;
    busRdEn = 0;
  endtask

  task automatic setPins(input logic [7:0] p);
    @(negedge clk);
    padIn = p;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] d, input logic [7:0] q, input logic [7:0] p);
    return (d & q) | (~d & p);
  endfunction

  initial begin
    #400000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    // R1 reset state, single-chip mode
    doReset(3'd7);
    @(negedge clk);
    check("R1 oe", padOe, 8'h00);
    check("R1 out", padOut, 8'h00);
    setPins(8'h5A);
    rd(DATA, rv); check("R1 data read", rv, 8'h5A);

    // R5 synchronizer latency
    @(negedge clk); padIn = 8'hC3;
    @(negedge clk); rd(DATA, rv);
    // rd samples after one more negedge: two edges have passed
    check("R5 after two edges", rv, 8'hC3);
    @(negedge clk); padIn = 8'h3C;
    @(posedge clk); #1 busAddr = DATA; busRdEn = 1; #0.5 rv = busRdData; busRdEn = 0;
    check("R5 after one edge", rv, 8'hC3);
    @(posedge clk); #1 busAddr = DATA; busRdEn = 1; #0.5 rv = busRdData; busRdEn = 0;
    check("R5 after second edge", rv, 8'h3C);

    // R2/R3/R4 random single-chip traffic
    mDir = 0; mData = 0; mPin = 8'h3C;
    for (int i = 0; i < 150; i++) begin
      int op = $urandom_range(0, 2);
      logic [7:0] v = 8'($urandom);
      if (op == 0) begin wr(DIRA, v); mDir = v; end
      else if (op == 1) begin wr(DATA, v); mData = v; end
      else begin setPins(v); mPin = v; end
      @(negedge clk);
      check("R2 oe", padOe, mDir);
      check("R2 out", padOut, mData);
      rd(DATA, rv); check("R4 data read", rv, expRead(mDir, mData, mPin));
      rd(DIRA, rv); check("R3 dir read", rv, 8'hFF);
    end
    // neighbouring address does not touch registers
    wr(16'hFF89, ~mData); wr(16'hFF8B, ~mDir);
    @(negedge clk);
    check("R3 neighbour dir", padOe, mDir);
    check("R4 neighbour data", padOut, mData);

    // R7 software standby
    wr(DIRA, 8'hA5); wr(DATA, 8'h69);
    @(negedge clk); swStandby = 1;
    repeat (6) @(negedge clk);
    check("R7 oe held", padOe, 8'hA5);
    check("R7 out held", padOut, 8'h69);
    swStandby = 0;
    rd(DATA, rv); check("R7 data kept", rv, expRead(8'hA5, 8'h69, mPin));

    // R6 hardware standby
    @(negedge clk); hwStandby = 1;
    #0.5 check("R6 oe immediate", padOe, 8'h00);
    wr(DIRA, 8'hFF);
    @(negedge clk); check("R6 oe during", padOe, 8'h00);
    hwStandby = 0;
    @(negedge clk); check("R6 dir cleared", padOe, 8'h00);
    wr(DIRA, 8'hFF);
    @(negedge clk); check("R6 data kept", padOut, 8'h69);

    // R10 mode frozen after reset
    modeSel = 3'd1;
    repeat (3) @(negedge clk);
    check("R10 still single-chip", padOe, 8'hFF);
    wr(DIRA, 8'h00);
    @(negedge clk); check("R10 dir writable", padOe, 8'h00);

    // R8 expanded with on-chip memory
    doReset(3'd2);
    extAddr = 8'hB7;
    wr(DATA, 8'h18);
    wr(DIRA, 8'h0F);
    setPins(8'hE1);
    @(negedge clk);
    check("R8 oe", padOe, 8'h0F);
    check("R8 out addr", padOut & 8'h0F, 8'h07);
    rd(DATA, rv); check("R8 input read", rv, expRead(8'h0F, 8'h18, 8'hE1));
    doReset(3'd4);
    extAddr = 8'h4E; wr(DIRA, 8'hF0);
    @(negedge clk);
    check("R8 mode4 oe", padOe, 8'hF0);
    check("R8 mode4 out", padOut & 8'hF0, 8'h40);

    // R9 expanded without on-chip memory
    doReset(3'd3);
    extAddr = 8'h92;
    @(negedge clk);
    check("R9 oe forced", padOe, 8'hFF);
    check("R9 out addr", padOut, 8'h92);
    wr(DIRA, 8'h00);
    @(negedge clk); check("R9 dir write ignored", padOe, 8'hFF);
    rd(DIRA, rv); check("R9 dir read", rv, 8'hFF);
    wr(DATA, 8'h5C);
    rd(DATA, rv); check("R9 data read", rv, 8'h5C);
    doReset(3'd1);
    @(negedge clk); check("R9 mode1 oe", padOe, 8'hFF);
    @(negedge clk); hwStandby = 1;
    #0.5 check("R6 oe romless", padOe, 8'h00);
    hwStandby = 0;

    // R1 reset after activity
    doReset(3'd0);
    @(negedge clk);
    check("R1 oe after reset", padOe, 8'h00);
    check("R1 out after reset", padOut, 8'h00);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule